// File: doc/BRIEF.md
# Trimmable Start-of-Frame Interval Timer

This block is the frame clock of a host-side serial bus controller. While enabled it emits a one-cycle start-of-frame pulse at a fixed spacing. The spacing, in clock periods, comes from an interval value that software can rewrite at any time. This lets the host lengthen or shorten its frames to stay in step with an external device. The timer also presents the number of clock periods left in the current frame and a wrapping frame number.

A write to the interval never changes the frame that is already running. Each write goes to a shadow register and sets a pending flag. At the next reload the pending value becomes the active interval, so the new spacing starts with the following frame. If several writes land in one frame, only the last one counts. A write made on the reload cycle itself belongs to the frame after the one that is starting.

When the timer is disabled it stays idle with the active interval on its count output. Enabling it starts a frame at once with a start-of-frame pulse.

Top module: `sof_frame_timer`

## Requirements
- R1: After reset, `sof` is 0, `frame_num` is 0 and `remaining` equals the RESET_INTERVAL parameter.
- R2: While enabled, `sof` is high for exactly one cycle per frame. Consecutive pulses are spaced by the active interval in clock periods. For example, an active interval of 400 gives pulses 400 cycles apart.
- R3: An interval written during a frame does not change the length of that frame. It sets the length of every frame from the next reload onwards. For example, writing 450 while the interval is 400 finishes the current frame at 400 and then gives 450-cycle frames.
- R4: If more than one write occurs within one frame, only the last written value is applied at the next reload.
- R5: A write made in the same cycle as a `sof` pulse does not affect the frame that starts there. It takes effect at the reload after that.
- R6: While `run_en` is 0, no `sof` is produced and `remaining` shows the active interval. The first enabled cycle after a disabled cycle produces `sof`.
- R7: A written interval of 0 is treated as 1, so the timer then pulses `sof` on every enabled cycle. `remaining` is never 0 while enabled.
- R8: `frame_num` increments by one in the cycle after each `sof`, holds otherwise, and wraps from 2047 to 0 at the default 11-bit width.
- R9: Within a frame of length N that starts with `sof` in cycle t, `remaining` reads N-k+1 in cycle t+k for k = 1..N. It reads 1 on the cycle of the next `sof`.
- R10: An interval written while disabled is applied at the frame started by re-enabling. That first frame has the written length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Timer enable |
| wr_en | input | 1 | Interval write strobe |
| wr_data | input | CNT_W | Interval value to write, in clock periods |
| sof | output | 1 | One-cycle start-of-frame pulse, asserted on the reload cycle |
| remaining | output | CNT_W | Clock periods left in the current frame |
| frame_num | output | FNUM_W | Frame number, advanced by each `sof` |

## Verification
`sof` is decoded from the count register, the running flag and `run_en`, so it is due in the same cycle as the input that enables it. `remaining` and `frame_num` change one edge after the cycle that causes the change. An interval write shows up only in the spacing of pulses, one reload after the write. The bench drives inputs on the falling edge and samples all outputs 1 ns later, before the next rising edge. It keeps an age-and-length model that is advanced once per rising edge, and compares every cycle against it. Separate checks measure the spacing between observed pulses for the exact frame lengths each requirement predicts.

// File: rtl/sof_timer_pkg.sv
package sof_timer_pkg;

  // An interval of zero would never expire; clamp it to one period.
  function automatic int unsigned ivl_floor(input int unsigned v);
    return (v == 0) ? 32'd1 : v;
  endfunction

  // Next frame number, wrapping modulo 2**w.
  function automatic int unsigned fnum_next(input int unsigned f, input int unsigned w);
    return (f + 1) % (32'd1 << w);
  endfunction

endpackage

// File: rtl/sof_interval_shadow.sv
module sof_interval_shadow
  import sof_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_IVL = 12000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             reload,
  output logic [CNT_W-1:0] active_ivl,
  output logic [CNT_W-1:0] next_ivl,
  output logic             pend_q
);

  localparam logic [CNT_W-1:0] IVL_INIT = CNT_W'(ivl_floor(RST_IVL));

  logic [CNT_W-1:0] shadow_q;

  // The value a reload would adopt: a pending write, otherwise the current interval.
  always_comb next_ivl = pend_q ? shadow_q : active_ivl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      pend_q     <= 1'b0;
      active_ivl <= IVL_INIT;
    end else begin
      if (reload) active_ivl <= next_ivl;
      if (wr_en) begin
        // A write on the reload cycle is kept for the frame after.
        shadow_q <= CNT_W'(ivl_floor(32'(wr_data)));
        pend_q   <= 1'b1;
      end else if (reload) begin
        pend_q   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sof_frame_counter.sv
module sof_frame_counter
  import sof_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_IVL = 12000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] next_ivl,
  input  logic [CNT_W-1:0] active_ivl,
  output logic [CNT_W-1:0] cnt_q,
  output logic             reload,
  output logic             running_q
);

  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(ivl_floor(RST_IVL));
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic frame_end;
  logic frame_start;

  always_comb begin
    frame_end   = running_q && (cnt_q == CNT_LAST);
    frame_start = !running_q;
    reload      = run_en && (frame_start || frame_end);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= CNT_INIT;
      running_q <= 1'b0;
    end else begin
      running_q <= run_en;
      if (!run_en)     cnt_q <= active_ivl;
      else if (reload) cnt_q <= next_ivl;
      else             cnt_q <= cnt_q - CNT_LAST;
    end
  end

endmodule

// File: rtl/sof_frame_number.sv
module sof_frame_number
  import sof_timer_pkg::*;
#(
  parameter int FNUM_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [FNUM_W-1:0] fnum_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    fnum_q <= '0;
    else if (step) fnum_q <= FNUM_W'(fnum_next(32'(fnum_q), FNUM_W));
  end

endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer #(
  parameter int CNT_W          = 16,
  parameter int FNUM_W         = 11,
  parameter int RESET_INTERVAL = 12000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              sof,
  output logic [CNT_W-1:0]  remaining,
  output logic [FNUM_W-1:0] frame_num
);

  // Named internal events, also used by the bound checker.
  logic             reload_evt;
  logic             running_q;
  logic             pend_q;
  logic [CNT_W-1:0] active_ivl;
  logic [CNT_W-1:0] next_ivl;
  logic [CNT_W-1:0] cnt_q;

  sof_interval_shadow #(.CNT_W(CNT_W), .RST_IVL(RESET_INTERVAL)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .reload     (reload_evt),
    .active_ivl (active_ivl),
    .next_ivl   (next_ivl),
    .pend_q     (pend_q)
  );

  sof_frame_counter #(.CNT_W(CNT_W), .RST_IVL(RESET_INTERVAL)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .next_ivl   (next_ivl),
    .active_ivl (active_ivl),
    .cnt_q      (cnt_q),
    .reload     (reload_evt),
    .running_q  (running_q)
  );

  sof_frame_number #(.FNUM_W(FNUM_W)) u_fnum (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (reload_evt),
    .fnum_q (frame_num)
  );

  assign sof       = reload_evt;
  assign remaining = cnt_q;

endmodule

// File: rtl/sof_frame_timer_chk.sv
module sof_frame_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int FNUM_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              wr_en,
  input logic              sof,
  input logic [CNT_W-1:0]  remaining,
  input logic [FNUM_W-1:0] frame_num,
  input logic [CNT_W-1:0]  active_ivl,
  input logic              pend_q
);

  // R2: a reload with nothing pending restarts the count at the active interval
  p_reload_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !pend_q) |=> remaining == $past(active_ivl));

  // R3: the active interval only moves at a reload
  p_active_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(active_ivl));

  // R4: any write leaves a value pending
  p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pend_q);

  // R5: a reload without a write consumes the pending value
  p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !wr_en) |=> !pend_q);

  // R6: idle means no pulse and the count parked at the interval
  p_no_sof_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !sof);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> remaining == $past(active_ivl));

  p_start_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> sof);

  // R7: a running count never reads zero
  p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> remaining != '0);

  // R8: frame number steps on a pulse and holds otherwise
  p_fnum_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> frame_num == FNUM_W'($past(frame_num) + 1'b1));

  p_fnum_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(frame_num));

  // R9: between pulses the count falls by one each cycle
  p_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !sof) |=> remaining == $past(remaining) - 1'b1);

endmodule

bind sof_frame_timer sof_frame_timer_chk #(.CNT_W(CNT_W), .FNUM_W(FNUM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .wr_en      (wr_en),
  .sof        (sof),
  .remaining  (remaining),
  .frame_num  (frame_num),
  .active_ivl (active_ivl),
  .pend_q     (pend_q)
);

// File: tb/sof_frame_timer_test.sv
`timescale 1ns/1ps
module sof_frame_timer_test;

  localparam int CW   = 16;
  localparam int FW   = 11;
  localparam int IVL0 = 400;
  localparam int FMOD = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic          sof;
  logic [CW-1:0] remaining;
  logic [FW-1:0] frame_num;

  sof_frame_timer #(.CNT_W(CW), .FNUM_W(FW), .RESET_INTERVAL(IVL0)) uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en), .wr_data(wr_data),
    .sof(sof), .remaining(remaining), .frame_num(frame_num)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Model: frame length, age within the frame, pending write.
  int m_active = IVL0;
  int m_len = IVL0;
  int m_age = 0;
  int m_pend = 0;
  bit m_pv = 0;
  bit m_run = 0;
  int m_fn = 0;

  int cyc = 0;
  int last_sof_cyc = 0;
  int period = 0;
  bit obs_sof;
  int obs_rem;
  int obs_fn;

  function automatic int floor1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit en, input bit we, input int wd);
    bit es;
    int er;
    @(negedge clk);
    run_en = en; wr_en = we; wr_data = CW'(wd);
    #1;
    es = en && (!m_run || m_age == m_len);
    er = m_run ? (m_len - m_age + 1) : m_active;
    obs_sof = sof; obs_rem = int'(remaining); obs_fn = int'(frame_num);
    chk(sof == es, "R2/R6 sof timing", int'(sof), int'(es));
    chk(obs_rem == er, "R9 remaining", obs_rem, er);
    chk(obs_fn == m_fn, "R8 frame number", obs_fn, m_fn);
    if (sof) begin period = cyc - last_sof_cyc; last_sof_cyc = cyc; end
    @(posedge clk);
    cyc++;
    if (es) begin
      m_len = m_pv ? m_pend : m_active;
      m_active = m_len; m_pv = 0; m_age = 1;
      m_fn = (m_fn + 1) % FMOD;
    end else if (en) begin
      m_age++;
    end
    if (we) begin m_pend = floor1(wd); m_pv = 1; end
    m_run = en;
  endtask

  task automatic wait_sof();
    for (int i = 0; i < 5000; i++) begin
      step(1, 0, 0);
      if (obs_sof) return;
    end
    chk(0, "R2 pulse missing", 0, 1);
  endtask

  task automatic to_sof_edge();
    for (int i = 0; i < 5000; i++) begin
      if (m_run && m_age == m_len) return;
      step(1, 0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f0;
    int cnt1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(sof == 1'b0, "R1 reset sof", int'(sof), 0);
    chk(int'(remaining) == IVL0, "R1 reset remaining", int'(remaining), IVL0);
    chk(int'(frame_num) == 0, "R1 reset frame number", int'(frame_num), 0);

    for (int i = 0; i < 10; i++) step(0, 0, 0);               // R6 idle
    step(1, 0, 0);
    chk(obs_sof == 1'b1, "R6 pulse on enable", int'(obs_sof), 1);
    wait_sof();
    chk(period == 400, "R2 frame period", period, 400);

    for (int i = 0; i < 100; i++) step(1, 0, 0);
    step(1, 1, 450);                                           // R3 mid-frame write
    wait_sof();
    chk(period == 400, "R3 running frame kept", period, 400);
    wait_sof();
    chk(period == 450, "R3 new frame length", period, 450);

    for (int i = 0; i < 10; i++) step(1, 0, 0);
    step(1, 1, 300);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    step(1, 1, 420);                                           // R4 last write wins
    wait_sof();
    chk(period == 450, "R4 running frame kept", period, 450);
    wait_sof();
    chk(period == 420, "R4 last write applied", period, 420);

    to_sof_edge();
    step(1, 1, 200);                                           // R5 write on pulse cycle
    chk(obs_sof == 1'b1, "R5 write lands on pulse", int'(obs_sof), 1);
    wait_sof();
    chk(period == 420, "R5 starting frame unchanged", period, 420);
    wait_sof();
    chk(period == 200, "R5 applied one reload later", period, 200);

    step(1, 1, 0);                                             // R7 zero interval
    wait_sof();
    cnt1 = 0;
    for (int i = 0; i < 6; i++) begin step(1, 0, 0); cnt1 += int'(obs_sof); end
    chk(cnt1 == 6, "R7 pulse every cycle", cnt1, 6);

    step(1, 0, 0);
    f0 = obs_fn;
    for (int i = 0; i < 2100; i++) step(1, 0, 0);              // R8 wrap
    chk(obs_fn == (f0 + 2100) % FMOD, "R8 wrap", obs_fn, (f0 + 2100) % FMOD);

    step(1, 1, 5);
    wait_sof();
    wait_sof();
    chk(period == 5, "R5 interval 5 applied", period, 5);
    step(1, 0, 0); step(1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0);
    chk(obs_rem == 5 && obs_sof == 1'b0, "R6 idle parks at interval", obs_rem, 5);
    step(0, 1, 7);                                             // R10 write while idle
    step(0, 0, 0);
    step(1, 0, 0);
    chk(obs_sof == 1'b1, "R10 pulse on re-enable", int'(obs_sof), 1);
    wait_sof();
    chk(period == 7, "R10 idle write applied", period, 7);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule